// File: doc/BRIEF.md
# Serial/parallel step attenuator controller

This block is the digital control front end of a six-bit stepped attenuator with half-decibel steps. It drives a registered, active-low control word. When every bit is one, the attenuator is in its reference (0 dB) state. Each cleared bit adds its own step, from 0.5 dB for bit 0 up to 16 dB for bit 5. The word can be loaded in three ways:
- a three-wire serial port (data, clock and latch enable), with a serial output so that further devices can be chained;
- a parallel word that the output follows while latch enable is high;
- the same parallel word, captured only by a latch-enable pulse.

All pins are treated as asynchronous. They pass through a synchronizer, and the serial clock is then edge-detected in the system clock domain.

After reset the block waits a parameterised number of clock cycles. During that wait it holds the maximum-attenuation word. When the wait ends, it loads the power-up word, which depends on the synchronized latch-enable level. If latch enable is low, two preset pins select one of four fixed words. If it is high, the parallel word is used.

Top module: `step_atten_ctrl`

## Requirements
- R1: From reset until PWRUP_CYCLES clock cycles have elapsed, `ctrl_o` is 000000 and `sdo_o` is 0.
- R2: If latch enable is low when the wait ends, `preset_i` selects the power-up word, with bit 0 as the first select pin and bit 1 as the second. The mapping is: 2'b00 gives 000000, 2'b01 gives 001111, 2'b10 gives 011111 and 2'b11 gives 111111.
- R3: If latch enable is high when the wait ends, the power-up word is `par_i`, and it is also loaded into the serial shift register.
- R4: In serial mode (`ser_mode_i`=1), each rising edge of `sclk_i` shifts `sdat_i` into bit 0 while the other bits move up one place. After six edges, the first bit sent sits in bit 5. While latch enable is high, the shift register is copied to `ctrl_o`.
- R5: In serial mode, rising edges of `sclk_i` that arrive while latch enable is high change neither the shift register nor `sdo_o`.
- R6: `sdo_o` takes the value of bit 5 as it leaves the register on each accepted shift. After shift n (n > 6), it therefore carries the bit sent at shift n-6.
- R7: While `ser_mode_i` is 0, `sdat_i` and `sclk_i` affect neither the shift register nor `sdo_o`.
- R8: In parallel mode with latch enable held high, `ctrl_o` follows `par_i`. A change on the pins appears on the third rising clock edge after it, and not earlier.
- R9: In parallel mode with latch enable low, `ctrl_o` ignores `par_i`. A latch-enable pulse loads the current `par_i`.
- R10: In serial mode, `ctrl_o` stays constant while latch enable is low, even while bits are being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; it starts the power-up wait |
| ser_mode_i | input | 1 | 1 = serial control, 0 = parallel control |
| sdat_i | input | 1 | Serial data, sent MSB first |
| sclk_i | input | 1 | Serial shift clock; data is taken on its rising edge |
| latch_i | input | 1 | Latch enable |
| par_i | input | 6 | Parallel control word, active low |
| preset_i | input | 2 | Power-up preset select |
| ctrl_o | output | 6 | Registered attenuation control word, active low |
| sdo_o | output | 1 | Serial output for chaining further devices |

## Verification
The hardest situations to reach from the ports are those where serial pins move while they are meant to be dead. This happens in two ways: clock edges that arrive while latch enable is high, and serial traffic sent while the block is in parallel mode. The effect of that traffic is hidden until a later transfer reveals the shift register. The stimulus therefore fills the register with a known word and sends random clock and data activity under masking or in parallel mode. It then switches back to serial mode and pulses latch enable, so the unchanged word must reappear on `ctrl_o`. The four presets and the parallel power-up each need their own reset with the pins held steady across the wait.

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int WORD_W       = 6,
  parameter int SYNC_STAGES  = 2,
  parameter int PWRUP_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode_i,
  input  logic              sdat_i,
  input  logic              sclk_i,
  input  logic              latch_i,
  input  logic [WORD_W-1:0] par_i,
  input  logic [1:0]        preset_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              sdo_o
);
  localparam int PIN_W = WORD_W + 6;
  localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWRUP_CYCLES - 1);

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic [PIN_W-1:0] stage_q [SYNC_STAGES];

  assign pins_raw = {preset_i, par_i, latch_i, sclk_i, sdat_i, ser_mode_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= pins_raw;
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign pins_s = stage_q[SYNC_STAGES-1];

  logic              mode_s, sdat_s, sclk_s, latch_s;
  logic [WORD_W-1:0] par_s;
  logic [1:0]        preset_s;

  assign mode_s   = pins_s[0];
  assign sdat_s   = pins_s[1];
  assign sclk_s   = pins_s[2];
  assign latch_s  = pins_s[3];
  assign par_s    = pins_s[4 +: WORD_W];
  assign preset_s = pins_s[4 + WORD_W +: 2];

  logic sclk_prev_q, sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;

  logic [CNT_W-1:0] cnt_q;
  logic             ready_q, expire;

  assign expire = !ready_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (expire) ready_q <= 1'b1;
      else        cnt_q   <= cnt_q + 1'b1;
    end
  end

  function automatic logic [WORD_W-1:0] preset_word(input logic [1:0] sel);
    logic [WORD_W-1:0] w;
    w = '1;
    case (sel)
      2'b00: w = '0;
      2'b01: begin w[WORD_W-1] = 1'b0; w[WORD_W-2] = 1'b0; end
      2'b10: w[WORD_W-1] = 1'b0;
      default: w = '1;
    endcase
    return w;
  endfunction

  logic [WORD_W-1:0] pwr_word, shreg_q;

  assign pwr_word = latch_s ? par_s : preset_word(preset_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o  <= '0;
      shreg_q <= '0;
      sdo_o   <= 1'b0;
    end else if (expire) begin
      ctrl_o  <= pwr_word;
      shreg_q <= pwr_word;
    end else if (ready_q) begin
      if (mode_s) begin
        if (latch_s) begin
          ctrl_o <= shreg_q;
        end else if (sclk_rise) begin
          shreg_q <= {shreg_q[WORD_W-2:0], sdat_s};
          sdo_o   <= shreg_q[WORD_W-1];
        end
      end else if (latch_s) begin
        ctrl_o <= par_s;
      end
    end
  end
endmodule

// File: rtl/step_atten_ctrl_chk.sv
module step_atten_ctrl_chk #(
  parameter int WORD_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready_q,
  input logic              mode_s,
  input logic              latch_s,
  input logic              sclk_rise,
  input logic [WORD_W-1:0] shreg_q,
  input logic [WORD_W-1:0] par_s,
  input logic [WORD_W-1:0] ctrl_o,
  input logic              sdo_o
);
  assert_wait_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |-> (ctrl_o == '0 && !sdo_o));

  assert_serial_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && mode_s && latch_s |=> ctrl_o == $past(shreg_q));

  assert_clock_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && mode_s && latch_s |=> $stable(shreg_q) && $stable(sdo_o));

  assert_cascade_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && mode_s && !latch_s && sclk_rise |=> sdo_o == $past(shreg_q[WORD_W-1]));

  assert_parallel_ignores_serial_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && !mode_s |=> $stable(shreg_q) && $stable(sdo_o));

  assert_direct_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && !mode_s && latch_s |=> ctrl_o == $past(par_s));

  // also covers R10 for serial mode
  assert_hold_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && !latch_s |=> $stable(ctrl_o));
endmodule

bind step_atten_ctrl step_atten_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready_q   (ready_q),
  .mode_s    (mode_s),
  .latch_s   (latch_s),
  .sclk_rise (sclk_rise),
  .shreg_q   (shreg_q),
  .par_s     (par_s),
  .ctrl_o    (ctrl_o),
  .sdo_o     (sdo_o)
);

// File: tb/test_step_atten_ctrl.sv
`timescale 1ns/1ps
module test_step_atten_ctrl;
  localparam int PW = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b1, sdat = 1'b0, sclk = 1'b0, latch = 1'b0;
  logic [5:0] par = '0;
  logic [1:0] preset = '0;
  logic [5:0] ctrl;
  logic       sdo;

  int n_chk = 0, n_bad = 0;
  logic [5:0] model;
  logic       sdo_exp;

  always #2.5 clk = ~clk;

  step_atten_ctrl #(.PWRUP_CYCLES(PW)) i_step_atten_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_mode_i(mode), .sdat_i(sdat), .sclk_i(sclk),
    .latch_i(latch), .par_i(par), .preset_i(preset), .ctrl_o(ctrl), .sdo_o(sdo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [5:0] exp_preset(input logic [1:0] s);
    case (s)
      2'b00: return 6'b000000;
      2'b01: return 6'b001111;
      2'b10: return 6'b011111;
      default: return 6'b111111;
    endcase
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up(input logic le, input logic [1:0] pre, input logic [5:0] p, input logic m);
    @(negedge clk);
    rst_n = 1'b0; latch = le; preset = pre; par = p; mode = m; sclk = 1'b0; sdat = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(PW / 2);
    check("R1 ctrl during wait", ctrl, 6'b000000);
    check("R1 sdo during wait", sdo, 1'b0);
    wait_n(PW);
    if (le) check("R3 parallel power-up word", ctrl, p);
    else    check("R2 preset power-up word", ctrl, exp_preset(pre));
    model = le ? p : exp_preset(pre);
    sdo_exp = 1'b0;
  endtask

  task automatic shift_bit(input logic b);
    sdat = b; wait_n(3);
    sclk = 1'b1; wait_n(4);
    sclk = 1'b0; wait_n(4);
  endtask

  task automatic pulse_latch();
    latch = 1'b1; wait_n(4);
    latch = 1'b0; wait_n(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [5:0] w, hold;
    void'($urandom(32'd624));

    for (int s = 0; s < 4; s++) power_up(1'b0, 2'(s), 6'($urandom), 1'b1);

    w = 6'($urandom);
    power_up(1'b1, 2'b00, w, 1'b0);

    // R8: direct parallel, exact three-edge latency
    for (int k = 0; k < 6; k++) begin
      hold = ctrl;
      w = 6'($urandom) ^ hold;
      if (w == hold) w = ~hold;
      par = w;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R8 not before third edge", ctrl, hold);
      @(negedge clk);
      check("R8 follows on third edge", ctrl, w);
    end

    // R9: latched parallel
    latch = 1'b0; wait_n(4);
    hold = ctrl;
    for (int k = 0; k < 4; k++) begin
      par = 6'($urandom); wait_n(5);
      check("R9 hold while latch low", ctrl, hold);
    end
    w = ~hold; par = w; wait_n(4);
    pulse_latch();
    check("R9 pulse loads parallel word", ctrl, w);

    // R7: serial activity in parallel mode is ignored
    for (int k = 0; k < 8; k++) begin
      shift_bit(1'($urandom));
      check("R7 sdo unchanged in parallel mode", sdo, sdo_exp);
    end
    mode = 1'b1; wait_n(4);
    pulse_latch();
    check("R7 shift register unchanged in parallel mode", ctrl, model);

    // R4, R6, R10: random serial words, cascaded output
    for (int k = 0; k < 20; k++) begin
      hold = ctrl;
      w = 6'($urandom);
      for (int b = 5; b >= 0; b--) begin
        shift_bit(w[b]);
        sdo_exp = model[5];
        model = {model[4:0], w[b]};
        check("R6 cascade output", sdo, sdo_exp);
      end
      check("R10 serial hold while latch low", ctrl, hold);
      pulse_latch();
      check("R4 serial word MSB first", ctrl, w);
    end

    // R5: clock edges masked while latch high
    w = 6'b101100;
    for (int b = 5; b >= 0; b--) begin
      shift_bit(w[b]);
      sdo_exp = model[5];
      model = {model[4:0], w[b]};
    end
    latch = 1'b1; wait_n(4);
    check("R4 transfer during latch high", ctrl, w);
    for (int k = 0; k < 5; k++) begin
      shift_bit(1'($urandom));
      check("R5 sdo unchanged while masked", sdo, sdo_exp);
    end
    latch = 1'b0; wait_n(4);
    pulse_latch();
    check("R5 shift register unchanged while masked", ctrl, w);

    summary();
  end
endmodule